// File: doc/BRIEF.md
# Maskable Interrupt Flag and Enable Unit

This block collects seven interrupt sources of a peripheral controller into one active-low request line. Each source raises its own sticky flag with a one-cycle set pulse. A flag stays set until its source asks for a clear, until the processor writes a one to it, or, for the serial shifter's flag, until the processor reads or writes the shifter's register. A separate seven-bit enable mask chooses which flags may drive the request line.

The processor reaches the unit through a small register bus. One address holds the flag register. Its top bit is a computed summary: it is 1 whenever an enabled flag is set, and it cannot be written. A second address holds the enable mask. A write to the mask uses bit 7 as an operation select. When bit 7 is 1, the bits written as ones are set. When bit 7 is 0, the bits written as ones are cleared. Bits written as zeros keep their value in both cases. The request line is low exactly while the summary bit is 1.

Top module: `irq_flag_unit`

## Requirements
- R1: While reset is held and after it is released, all flags and all enable bits are 0, `irq_n` is 1, a read at address 13 returns 0x00 and a read at address 14 returns 0x80.
- R2: A 1 on `src_set[i]` in a cycle sets flag i at the next clock edge. The flag then stays set until one of the clears of R5, R9 or R10 acts on it.
- R3: A read at address 13 returns the flags in bits 6:0 with this layout: bit 0 is port A line 2, bit 1 is port A line 1, bit 2 is the shifter, bit 3 is port B line 2, bit 4 is port B line 1, bit 5 is timer two and bit 6 is timer one.
- R4: Bit 7 of a read at address 13 is 1 exactly when some flag and its enable bit are both 1. `irq_n` is the inverse of that bit, and it follows the register state in the same cycle.
- R5: A write at address 13 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Data bit 7 of such a write has no effect.
- R6: A write at address 14 with data bit 7 = 1 sets each enable bit whose data bit is 1. The other enable bits keep their value.
- R7: A write at address 14 with data bit 7 = 0 clears each enable bit whose data bit is 1. The other enable bits keep their value.
- R8: A read at address 14 returns the enable bits in bits 6:0 and returns 1 in bit 7.
- R9: A 1 on `src_clr[i]` clears flag i at the next edge. When a set and any clear (source, bus write or shifter access) reach the same flag in the same cycle, the flag ends up set.
- R10: Any read or write at address 10 clears flag bit 2 and leaves the other flags unchanged.
- R11: A read at any address other than 13 and 14 returns 0. A write to any address other than 10, 13 and 14 changes no flag and no enable bit. A read at address 13 or 14 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | 7 | Per-source set pulses |
| src_clr | input | 7 | Per-source clear requests |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the state and the address |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Suppose a flag or an enable bit holds a wrong value. The next read of address 13 or 14 shows it in the returned bits. If the bad bit meets a set partner bit, `irq_n` shows it in the very cycle after the edge that stored it. The reference model tracks both registers cycle by cycle and compares `irq_n` and `bus_rdata` after every clock edge, so a wrong clear mask, a lost set, or the wrong operation on a mask write is seen within one cycle of the access that exposes it. The stimulus reads both registers often, so a wrong bit does not stay hidden for long.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } bus_acc_e;

    localparam int unsigned SRC_COUNT_DEF  = 7;
    localparam int unsigned ADDR_W_DEF     = 4;
    localparam int unsigned FLAG_ADDR_DEF  = 13;
    localparam int unsigned MASK_ADDR_DEF  = 14;
    localparam int unsigned SHIFT_ADDR_DEF = 10;
    localparam int unsigned SHIFT_BIT_DEF  = 2;

endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] flags_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] flags;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic [NUM_SRC-1:0] bit_next;

    // One next-state cell per source: a set overrides every clear.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        assign bit_next[g] = set_i[g] | (st_q.flags[g] & ~clr_i[g]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = bit_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               set_mode_i,
    input  logic [NUM_SRC-1:0] bits_i,
    output logic [NUM_SRC-1:0] en_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            if (set_mode_i) begin
                st_d.en = st_q.en | bits_i;
            end else begin
                st_d.en = st_q.en & ~bits_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic               summary_o,
    output logic               irq_n_o
);

    logic [NUM_SRC-1:0] pending;

    assign pending   = flags_i & en_i;
    assign summary_o = |pending;
    assign irq_n_o   = ~summary_o;

endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit #(
    parameter int unsigned NUM_SRC    = irq_pkg::SRC_COUNT_DEF,
    parameter int unsigned ADDR_W     = irq_pkg::ADDR_W_DEF,
    parameter int unsigned FLAG_ADDR  = irq_pkg::FLAG_ADDR_DEF,
    parameter int unsigned MASK_ADDR  = irq_pkg::MASK_ADDR_DEF,
    parameter int unsigned SHIFT_ADDR = irq_pkg::SHIFT_ADDR_DEF,
    parameter int unsigned SHIFT_BIT  = irq_pkg::SHIFT_BIT_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic [NUM_SRC-1:0] src_clr,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC:0]   bus_wdata,
    output logic [NUM_SRC:0]   bus_rdata,
    output logic               irq_n
);

    import irq_pkg::*;

    localparam int unsigned DATA_W = NUM_SRC + 1;
    localparam int unsigned OP_BIT = DATA_W - 1;

    bus_acc_e           acc;
    logic               hit_flag, hit_mask, hit_shift;
    logic               flag_wr, mask_wr;
    logic [NUM_SRC-1:0] bus_clr, shift_clr, clr_all;
    logic [NUM_SRC-1:0] flags_q, en_q;
    logic               summary;

    always_comb begin
        if (!bus_sel) begin
            acc = ACC_IDLE;
        end else if (bus_wr) begin
            acc = ACC_WRITE;
        end else begin
            acc = ACC_READ;
        end
    end

    assign hit_flag  = (bus_addr == ADDR_W'(FLAG_ADDR));
    assign hit_mask  = (bus_addr == ADDR_W'(MASK_ADDR));
    assign hit_shift = (bus_addr == ADDR_W'(SHIFT_ADDR));

    assign flag_wr = (acc == ACC_WRITE) && hit_flag;
    assign mask_wr = (acc == ACC_WRITE) && hit_mask;

    always_comb begin
        shift_clr = '0;
        shift_clr[SHIFT_BIT] = (acc != ACC_IDLE) && hit_shift;
    end

    assign bus_clr = flag_wr ? bus_wdata[NUM_SRC-1:0] : '0;
    assign clr_all = src_clr | bus_clr | shift_clr;

    irq_flag_reg #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (src_set),
        .clr_i   (clr_all),
        .flags_o (flags_q)
    );

    irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (mask_wr),
        .set_mode_i (bus_wdata[OP_BIT]),
        .bits_i     (bus_wdata[NUM_SRC-1:0]),
        .en_o       (en_q)
    );

    irq_summary #(.NUM_SRC(NUM_SRC)) u_sum (
        .flags_i   (flags_q),
        .en_i      (en_q),
        .summary_o (summary),
        .irq_n_o   (irq_n)
    );

    always_comb begin
        bus_rdata = '0;
        if (acc == ACC_READ) begin
            if (hit_flag) begin
                bus_rdata = {summary, flags_q};
            end else if (hit_mask) begin
                bus_rdata = {1'b1, en_q};
            end
        end
    end

endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk #(
    parameter int unsigned NUM_SRC   = 7,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned FLAG_ADDR = 13,
    parameter int unsigned MASK_ADDR = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_set,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SRC:0]   bus_wdata,
    input logic [NUM_SRC:0]   bus_rdata,
    input logic               irq_n,
    input logic [NUM_SRC-1:0] flags_q,
    input logic [NUM_SRC-1:0] en_q
);

    logic flag_write, mask_write, flag_read;
    assign flag_write = bus_sel && bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR));
    assign mask_write = bus_sel && bus_wr && (bus_addr == ADDR_W'(MASK_ADDR));
    assign flag_read  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR));

    // R4: the summary bit on the read path agrees with the request pin
    a_r4_summary_matches_pin: assert property (@(posedge clk) disable iff (!rst_n)
        flag_read |-> (bus_rdata[NUM_SRC] == !irq_n));

    // R2 / R9: every set pulse lands, whatever clears arrive with it
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((flags_q & $past(src_set)) == $past(src_set)));

    // R2: no flag rises without a set pulse
    a_r2_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(src_set)) == '0));

    // R5: ones written to the flag register clear those flags
    a_r5_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_write && ((bus_wdata[NUM_SRC-1:0] & src_set) == '0))
        |=> ((flags_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

    // R6: set-mode mask write turns the selected bits on
    a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_write && bus_wdata[NUM_SRC])
        |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

    // R7: clear-mode mask write turns the selected bits off
    a_r7_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_write && !bus_wdata[NUM_SRC])
        |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

    // R11: the mask only moves on a mask write
    a_r11_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_write |=> $stable(en_q));

endmodule

bind irq_flag_unit irq_flag_unit_chk #(
    .NUM_SRC   (NUM_SRC),
    .ADDR_W    (ADDR_W),
    .FLAG_ADDR (FLAG_ADDR),
    .MASK_ADDR (MASK_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_set   (src_set),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n),
    .flags_q   (flags_q),
    .en_q      (en_q)
);

// File: tb/irq_flag_unit_tb_top.sv
`timescale 1ns/1ps
module irq_flag_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src_set = '0;
    logic [6:0] src_clr = '0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference state
    int m_flags = 0;
    int m_en = 0;

    always #2.5 clk = ~clk;

    irq_flag_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_set   (src_set),
        .src_clr   (src_clr),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    task automatic model_edge();
        int clr;
        if (!rst_n) begin
            m_flags = 0;
            m_en = 0;
        end else begin
            clr = int'(src_clr);
            if (bus_sel && bus_wr && bus_addr == 4'd13) clr = clr | (int'(bus_wdata) & 'h7f);
            if (bus_sel && bus_addr == 4'd10) clr = clr | 'h04;
            m_flags = ((m_flags & ~clr) | int'(src_set)) & 'h7f;
            if (bus_sel && bus_wr && bus_addr == 4'd14) begin
                if (bus_wdata[7]) m_en = m_en | (int'(bus_wdata) & 'h7f);
                else              m_en = m_en & ~(int'(bus_wdata) & 'h7f);
            end
        end
    endtask

    task automatic compare(input string tag);
        int exp_rd;
        int exp_irq;
        exp_irq = ((m_flags & m_en) != 0) ? 0 : 1;
        exp_rd = 0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == 4'd13) exp_rd = (((m_flags & m_en) != 0) ? 'h80 : 0) | m_flags;
            else if (bus_addr == 4'd14) exp_rd = 'h80 | m_en;
        end
        checks++;
        if (int'(irq_n) != exp_irq) begin
            failures++;
            $display("FAIL %s irq_n actual=%0d expected=%0d", tag, irq_n, exp_irq);
        end
        checks++;
        if (int'(bus_rdata) != exp_rd) begin
            failures++;
            $display("FAIL %s rdata actual=0x%02h expected=0x%02h", tag, bus_rdata, exp_rd[7:0]);
        end
    endtask

    // one cycle: drive at the falling edge, model at the rising edge, compare at the next falling edge
    task automatic cyc(input logic sel, input logic wr, input logic [3:0] addr,
                       input logic [7:0] wd, input logic [6:0] st, input logic [6:0] cl,
                       input string tag);
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        src_set = st; src_clr = cl;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic rd(input logic [3:0] addr, input string tag);
        cyc(1'b1, 1'b0, addr, 8'h00, 7'h00, 7'h00, tag);
    endtask

    task automatic wrr(input logic [3:0] addr, input logic [7:0] d, input string tag);
        cyc(1'b1, 1'b1, addr, d, 7'h00, 7'h00, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1: state under reset
        rd(4'd13, "R1_flags_in_reset");
        cyc(1'b1, 1'b0, 4'd13, 8'h00, 7'h7f, 7'h00, "R1_set_ignored_in_reset");
        rd(4'd14, "R1_mask_in_reset");
        rst_n = 1'b1;
        rd(4'd13, "R1_flags_after_reset");
        rd(4'd14, "R1_mask_after_reset");

        // R2 / R3: each source sets its own bit, read back at address 13
        for (int i = 0; i < 7; i++) begin
            cyc(1'b0, 1'b0, 4'd0, 8'h00, 7'(1 << i), 7'h00, "R2_set_pulse");
            rd(4'd13, "R3_flag_layout");
        end
        rd(4'd13, "R2_flags_sticky");

        // R6 / R8 / R4: enable a few sources
        wrr(4'd14, 8'h82, "R6_enable_bit1");
        rd(4'd14, "R8_mask_read");
        rd(4'd13, "R4_summary_set");
        wrr(4'd14, 8'hc4, "R6_enable_bits6_2");
        rd(4'd14, "R8_mask_read2");

        // R7: clear-mode mask write
        wrr(4'd14, 8'h46, "R7_disable_bits");
        rd(4'd14, "R7_mask_after_clear");
        rd(4'd13, "R4_summary_cleared");

        // R5: write-one-to-clear, bit 7 ignored
        wrr(4'd14, 8'hff, "R6_enable_all");
        wrr(4'd13, 8'h85, "R5_clear_ones");
        rd(4'd13, "R5_flags_after_clear");
        wrr(4'd13, 8'h80, "R5_bit7_no_effect");
        rd(4'd13, "R5_flags_unchanged");

        // R9: source clear, and set beating every clear
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 7'h00, 7'h10, "R9_src_clear");
        rd(4'd13, "R9_after_src_clear");
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 7'h01, 7'h01, "R9_set_wins_src");
        cyc(1'b1, 1'b1, 4'd13, 8'h7f, 7'h08, 7'h00, "R9_set_wins_bus");
        rd(4'd13, "R9_read_after_race");
        cyc(1'b1, 1'b0, 4'd10, 8'h00, 7'h04, 7'h00, "R9_set_wins_shift");
        rd(4'd13, "R9_shift_race_read");

        // R10: shifter access clears bit 2 only
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 7'h7f, 7'h00, "R10_fill");
        rd(4'd10, "R10_read_clears");
        rd(4'd13, "R10_after_read");
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 7'h04, 7'h00, "R10_refill");
        wrr(4'd10, 8'h00, "R10_write_clears");
        rd(4'd13, "R10_after_write");

        // R11: other addresses
        for (int a = 0; a < 16; a++) begin
            if (a != 10 && a != 13 && a != 14) begin
                wrr(4'(a), 8'hff, "R11_foreign_write");
                wrr(4'(a), 8'h7f, "R11_foreign_write");
                rd(4'(a), "R11_foreign_read");
            end
        end
        rd(4'd13, "R11_flags_kept");
        rd(4'd14, "R11_mask_kept");
        rd(4'd13, "R11_read_no_side_effect");

        // mixed traffic, compared every cycle
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] a;
            int pick;
            pick = $urandom_range(0, 5);
            a = (pick == 0) ? 4'd13 : (pick == 1) ? 4'd14 : (pick == 2) ? 4'd10 : 4'($urandom_range(0, 15));
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, 8'($urandom),
                7'($urandom) & 7'($urandom), 7'($urandom) & 7'($urandom), "R9_mixed_traffic");
        end

        rst_n = 1'b0;
        rd(4'd14, "R1_second_reset");
        rst_n = 1'b1;
        rd(4'd13, "R1_after_second_reset");
        finish_run();
    end

endmodule